// File: doc/BRIEF.md
# Vector-Configuration Micro-Op Expander

This block sits after instruction decode and turns one vector-configuration instruction into the one or two micro-ops that the back end issues for it. Three instruction forms are accepted: a register-immediate form (length from a scalar register, type from an immediate), an immediate-immediate form (both from immediates) and a register-register form (both from scalar registers). With each instruction come the destination index and two source indices. Whether the first source and the destination are the zero register decides which micro-ops are produced. The choice is between a normal pair, a pair that sets the length to its maximum, and, when both are zero, a path that keeps the current length.

Micro-ops leave through a registered valid/ready output, one per cycle at most. Each carries an 8-bit function code, the register indices, grouping marks (first, last, group size) and fields decoded from the code. The decoded fields are the instruction form, the length mode, and the register regions read and written. A flush input drops whatever has not yet been handed over and puts the block back to idle. A parameter chooses whether a new instruction may be taken in the same cycle that the last micro-op of the previous one is handed over.

Top module: `vcx_uop_expander`

## Requirements
- R1: Register-immediate form (in_form 0) with rs1 not zero emits two micro-ops: function code 8'hA0 (configuration write), then 8'h80 (destination write).
- R2: Register-immediate form with rs1 zero and rd not zero emits 8'hA1, then 8'h81 (length set to maximum).
- R3: Register-immediate form with rs1 and rd both zero emits the single micro-op 8'hA2 (reads the old configuration, keeps the length, updates the type).
- R4: Register-register form (in_form 2) emits 8'h60 then 8'h40 when rs1 is not zero, and 8'h61 then 8'h41 when rs1 is zero and rd is not.
- R5: Register-register form with rs1 and rd both zero emits 8'h62 (source moved into a temporary vector register), then 8'h72 (configuration written from the old configuration and the temporary).
- R6: Immediate-immediate form (in_form 1) always emits 8'h20 then 8'h00, whatever the values of rs1 and rd.
- R7: out_kind decodes the code: bit 7 set gives 0 (register-immediate), else bit 6 set gives 2 (register-register), else 1 (immediate-immediate); out_set_vlmax is bit 0 and out_keep_vl is bit 1.
- R8: out_wr_vec is code bit 5 (set: writes the vector region, clear: the integer region) and out_rd_vec is code bit 4 (set: reads the vector region).
- R9: out_flush_pipe is high exactly on the last micro-op of a register-register instruction.
- R10: Each micro-op carries out_total (1 or 2), out_first on the first and out_last on the final micro-op, and the rd, rs1 and rs2 of its instruction unchanged.
- R11: A micro-op is held stable while out_valid is high and out_ready low; the second micro-op appears only after the first is accepted; in_ready stays low while a micro-op that is not the last one is pending.
- R12: A flush makes out_valid low in the following cycle, discards a pending second micro-op and holds in_ready low during the flush cycle.
- R13: After reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all micro-ops not yet handed over |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_form | input | 2 | 0 register-immediate, 1 immediate-immediate, 2 register-register |
| in_rd | input | IDX_W | Destination index |
| in_rs1 | input | IDX_W | First source index |
| in_rs2 | input | IDX_W | Second source index |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_func | output | 8 | Micro-op function code |
| out_rd | output | IDX_W | Destination index of the instruction |
| out_rs1 | output | IDX_W | First source index of the instruction |
| out_rs2 | output | IDX_W | Second source index of the instruction |
| out_first | output | 1 | First micro-op of its instruction |
| out_last | output | 1 | Final micro-op of its instruction |
| out_total | output | 2 | Micro-ops in this instruction (1 or 2) |
| out_kind | output | 2 | Instruction form decoded from out_func |
| out_set_vlmax | output | 1 | Length is set to its maximum |
| out_keep_vl | output | 1 | Length keeps its old value |
| out_wr_vec | output | 1 | Writes the vector register region |
| out_rd_vec | output | 1 | Reads the vector register region |
| out_flush_pipe | output | 1 | Pipeline flush needed after this micro-op |

## Verification
The checks assume that in_form never takes the reserved value 3 while in_valid is high, and that in_valid with its fields is held until the instruction is taken. The driver only picks forms 0 to 2 and keeps each instruction on the input until in_ready is seen high before the clock edge, then withdraws it at once. The consumer side drives out_ready always high, pseudo-randomly, or held low, so that the hold, pairing and flush rules are all seen under back-pressure.

// File: rtl/vcx_pkg.sv
package vcx_pkg;

   localparam int FUNC_W = 8;
   typedef logic [FUNC_W-1:0] func_t;

   localparam logic [1:0] FORM_RI = 2'd0;
   localparam logic [1:0] FORM_II = 2'd1;
   localparam logic [1:0] FORM_RR = 2'd2;

   localparam logic [1:0] VL_NORM  = 2'b00;
   localparam logic [1:0] VL_MAX   = 2'b01;
   localparam logic [1:0] VL_KEEP  = 2'b10;

   function automatic func_t make_code(logic ri, logic rr, logic wv, logic rv, logic [1:0] vl);
      return {ri, rr, wv, rv, 2'b00, vl};
   endfunction

   localparam func_t C_RI_CFG      = make_code(1'b1, 1'b0, 1'b1, 1'b0, VL_NORM);
   localparam func_t C_RI_DST      = make_code(1'b1, 1'b0, 1'b0, 1'b0, VL_NORM);
   localparam func_t C_RI_CFG_MAX  = make_code(1'b1, 1'b0, 1'b1, 1'b0, VL_MAX);
   localparam func_t C_RI_DST_MAX  = make_code(1'b1, 1'b0, 1'b0, 1'b0, VL_MAX);
   localparam func_t C_RI_KEEP     = make_code(1'b1, 1'b0, 1'b1, 1'b0, VL_KEEP);
   localparam func_t C_RR_CFG      = make_code(1'b0, 1'b1, 1'b1, 1'b0, VL_NORM);
   localparam func_t C_RR_DST      = make_code(1'b0, 1'b1, 1'b0, 1'b0, VL_NORM);
   localparam func_t C_RR_CFG_MAX  = make_code(1'b0, 1'b1, 1'b1, 1'b0, VL_MAX);
   localparam func_t C_RR_DST_MAX  = make_code(1'b0, 1'b1, 1'b0, 1'b0, VL_MAX);
   localparam func_t C_RR_TMP_MOVE = make_code(1'b0, 1'b1, 1'b1, 1'b0, VL_KEEP);
   localparam func_t C_RR_KEEP     = make_code(1'b0, 1'b1, 1'b1, 1'b1, VL_KEEP);
   localparam func_t C_II_CFG      = make_code(1'b0, 1'b0, 1'b1, 1'b0, VL_NORM);
   localparam func_t C_II_DST      = make_code(1'b0, 1'b0, 1'b0, 1'b0, VL_NORM);

   function automatic logic [1:0] code_kind(func_t f);
      if (f[7])      return FORM_RI;
      else if (f[6]) return FORM_RR;
      else           return FORM_II;
   endfunction

   function automatic logic code_vlmax(func_t f);
      return f[0];
   endfunction

   function automatic logic code_keep(func_t f);
      return f[1];
   endfunction

   function automatic logic code_wr_vec(func_t f);
      return f[5];
   endfunction

   function automatic logic code_rd_vec(func_t f);
      return f[4];
   endfunction

endpackage

// File: rtl/vcx_case_sel.sv
module vcx_case_sel
   import vcx_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic [1:0]       form,
   input  logic [IDX_W-1:0] rd,
   input  logic [IDX_W-1:0] rs1,
   output logic             two,
   output func_t            code_a,
   output func_t            code_b,
   output logic             is_rr
);

   logic rd_zero;
   logic rs1_zero;

   assign rd_zero  = (rd == '0);
   assign rs1_zero = (rs1 == '0);

   always_comb begin
      two    = 1'b1;
      is_rr  = 1'b0;
      code_a = C_II_CFG;
      code_b = C_II_DST;
      case (form)
         FORM_RI: begin
            if (!rs1_zero) begin
               code_a = C_RI_CFG;
               code_b = C_RI_DST;
            end else if (!rd_zero) begin
               code_a = C_RI_CFG_MAX;
               code_b = C_RI_DST_MAX;
            end else begin
               code_a = C_RI_KEEP;
               code_b = C_RI_KEEP;
               two    = 1'b0;
            end
         end
         FORM_RR: begin
            is_rr = 1'b1;
            if (!rs1_zero) begin
               code_a = C_RR_CFG;
               code_b = C_RR_DST;
            end else if (!rd_zero) begin
               code_a = C_RR_CFG_MAX;
               code_b = C_RR_DST_MAX;
            end else begin
               code_a = C_RR_TMP_MOVE;
               code_b = C_RR_KEEP;
            end
         end
         default: begin
            code_a = C_II_CFG;
            code_b = C_II_DST;
         end
      endcase
   end

endmodule

// File: rtl/vcx_code_dec.sv
module vcx_code_dec
   import vcx_pkg::*;
(
   input  func_t       func,
   output logic [1:0]  kind,
   output logic        set_vlmax,
   output logic        keep_vl,
   output logic        wr_vec,
   output logic        rd_vec
);

   assign kind      = code_kind(func);
   assign set_vlmax = code_vlmax(func);
   assign keep_vl   = code_keep(func);
   assign wr_vec    = code_wr_vec(func);
   assign rd_vec    = code_rd_vec(func);

endmodule

// File: rtl/vcx_seq.sv
module vcx_seq
   import vcx_pkg::*;
#(
   parameter int IDX_W        = 5,
   parameter bit BYPASS_READY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             two,
   input  func_t            code_a,
   input  func_t            code_b,
   input  logic             is_rr,
   input  logic [IDX_W-1:0] in_rd,
   input  logic [IDX_W-1:0] in_rs1,
   input  logic [IDX_W-1:0] in_rs2,
   output logic             out_valid,
   input  logic             out_ready,
   output func_t            out_func,
   output logic [IDX_W-1:0] out_rd,
   output logic [IDX_W-1:0] out_rs1,
   output logic [IDX_W-1:0] out_rs2,
   output logic             out_first,
   output logic             out_last,
   output logic [1:0]       out_total,
   output logic             out_flush_pipe
);

   logic             valid_q;
   logic             pend_q;
   func_t            func_q;
   func_t            pend_func_q;
   logic             first_q;
   logic             last_q;
   logic [1:0]       total_q;
   logic             rr_q;
   logic [IDX_W-1:0] rd_q;
   logic [IDX_W-1:0] rs1_q;
   logic [IDX_W-1:0] rs2_q;
   logic             take;
   logic             hand_over;
   logic             can_take;

   generate
      if (BYPASS_READY) begin : g_bypass
         assign can_take = !valid_q || (out_ready && last_q);
      end else begin : g_idle_only
         assign can_take = !valid_q;
      end
   endgenerate

   assign in_ready  = can_take && !flush;
   assign take      = in_valid && in_ready;
   assign hand_over = valid_q && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q     <= 1'b0;
         pend_q      <= 1'b0;
         func_q      <= '0;
         pend_func_q <= '0;
         first_q     <= 1'b0;
         last_q      <= 1'b0;
         total_q     <= 2'd0;
         rr_q        <= 1'b0;
         rd_q        <= '0;
         rs1_q       <= '0;
         rs2_q       <= '0;
      end else if (flush) begin
         valid_q <= 1'b0;
         pend_q  <= 1'b0;
      end else if (take) begin
         valid_q     <= 1'b1;
         func_q      <= code_a;
         pend_q      <= two;
         pend_func_q <= code_b;
         first_q     <= 1'b1;
         last_q      <= !two;
         total_q     <= two ? 2'd2 : 2'd1;
         rr_q        <= is_rr;
         rd_q        <= in_rd;
         rs1_q       <= in_rs1;
         rs2_q       <= in_rs2;
      end else if (hand_over) begin
         if (pend_q) begin
            func_q  <= pend_func_q;
            pend_q  <= 1'b0;
            first_q <= 1'b0;
            last_q  <= 1'b1;
         end else begin
            valid_q <= 1'b0;
         end
      end
   end

   assign out_valid      = valid_q;
   assign out_func       = func_q;
   assign out_rd         = rd_q;
   assign out_rs1        = rs1_q;
   assign out_rs2        = rs2_q;
   assign out_first      = first_q;
   assign out_last       = last_q;
   assign out_total      = total_q;
   assign out_flush_pipe = valid_q && last_q && rr_q;

endmodule

// File: rtl/vcx_uop_expander.sv
module vcx_uop_expander
   import vcx_pkg::*;
#(
   parameter int IDX_W        = 5,
   parameter bit BYPASS_READY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [1:0]       in_form,
   input  logic [IDX_W-1:0] in_rd,
   input  logic [IDX_W-1:0] in_rs1,
   input  logic [IDX_W-1:0] in_rs2,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_func,
   output logic [IDX_W-1:0] out_rd,
   output logic [IDX_W-1:0] out_rs1,
   output logic [IDX_W-1:0] out_rs2,
   output logic             out_first,
   output logic             out_last,
   output logic [1:0]       out_total,
   output logic [1:0]       out_kind,
   output logic             out_set_vlmax,
   output logic             out_keep_vl,
   output logic             out_wr_vec,
   output logic             out_rd_vec,
   output logic             out_flush_pipe
);

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("vcx_uop_expander: IDX_W must lie in 1..8");
      end
      if (FUNC_W != 8) begin : g_bad_func
         $error("vcx_uop_expander: function code must be 8 bits");
      end
   endgenerate

   logic  sel_two;
   logic  sel_rr;
   func_t sel_a;
   func_t sel_b;

   vcx_case_sel #(.IDX_W(IDX_W)) u_sel (
      .form   (in_form),
      .rd     (in_rd),
      .rs1    (in_rs1),
      .two    (sel_two),
      .code_a (sel_a),
      .code_b (sel_b),
      .is_rr  (sel_rr)
   );

   vcx_seq #(.IDX_W(IDX_W), .BYPASS_READY(BYPASS_READY)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .flush          (flush),
      .in_valid       (in_valid),
      .in_ready       (in_ready),
      .two            (sel_two),
      .code_a         (sel_a),
      .code_b         (sel_b),
      .is_rr          (sel_rr),
      .in_rd          (in_rd),
      .in_rs1         (in_rs1),
      .in_rs2         (in_rs2),
      .out_valid      (out_valid),
      .out_ready      (out_ready),
      .out_func       (out_func),
      .out_rd         (out_rd),
      .out_rs1        (out_rs1),
      .out_rs2        (out_rs2),
      .out_first      (out_first),
      .out_last       (out_last),
      .out_total      (out_total),
      .out_flush_pipe (out_flush_pipe)
   );

   vcx_code_dec u_dec (
      .func      (out_func),
      .kind      (out_kind),
      .set_vlmax (out_set_vlmax),
      .keep_vl   (out_keep_vl),
      .wr_vec    (out_wr_vec),
      .rd_vec    (out_rd_vec)
   );

endmodule

// File: rtl/vcx_uop_expander_chk.sv
module vcx_uop_expander_chk #(
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             in_valid,
   input logic             in_ready,
   input logic [1:0]       in_form,
   input logic             out_valid,
   input logic             out_ready,
   input logic [7:0]       out_func,
   input logic [IDX_W-1:0] out_rd,
   input logic             out_first,
   input logic             out_last,
   input logic [1:0]       out_total,
   input logic [1:0]       out_kind,
   input logic             out_keep_vl,
   input logic             out_flush_pipe
);

   assert_form_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> in_form != 2'd3);

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=>
         (out_valid && $stable(out_func) && $stable(out_rd) && $stable(out_first) && $stable(out_last)));

   assert_no_take_mid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> !in_ready);

   assert_second_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last && !flush) |=> (out_valid && !out_first && out_last));

   assert_marks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_total == 2'd1) ? (out_first && out_last) :
                     ((out_total == 2'd2) && (out_first != out_last))));

   assert_single_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_keep_vl && out_kind == 2'd0) |-> (out_first && out_last));

   assert_tmp_then_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_func == 8'h62 && !flush) |=> (out_valid && out_func == 8'h72));

   assert_flush_pipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_flush_pipe |-> (out_valid && out_last && out_kind == 2'd2));

   assert_flush_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);

   assert_flush_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !in_ready);

endmodule

bind vcx_uop_expander vcx_uop_expander_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/vcx_uop_expander_test.sv
module vcx_uop_expander_test;

   localparam int IDX_W = 5;
   localparam int W = 34;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             flush = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [1:0]       in_form = 2'd0;
   logic [IDX_W-1:0] in_rd = '0;
   logic [IDX_W-1:0] in_rs1 = '0;
   logic [IDX_W-1:0] in_rs2 = '0;
   logic             out_valid;
   logic             out_ready = 1'b0;
   logic [7:0]       out_func;
   logic [IDX_W-1:0] out_rd;
   logic [IDX_W-1:0] out_rs1;
   logic [IDX_W-1:0] out_rs2;
   logic             out_first;
   logic             out_last;
   logic [1:0]       out_total;
   logic [1:0]       out_kind;
   logic             out_set_vlmax;
   logic             out_keep_vl;
   logic             out_wr_vec;
   logic             out_rd_vec;
   logic             out_flush_pipe;

   int checks = 0;
   int bad = 0;
   int rdy_mode = 0;
   bit done = 1'b0;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];

   always #2ns clk = ~clk;

   vcx_uop_expander #(.IDX_W(IDX_W), .BYPASS_READY(1'b1)) uut (.*);

   function automatic logic [W-1:0] mk(logic [7:0] f, logic [IDX_W-1:0] rd, logic [IDX_W-1:0] r1,
                                       logic [IDX_W-1:0] r2, logic fi, logic la, logic [1:0] tot,
                                       logic [1:0] form, logic fp);
      return {f, rd, r1, r2, fi, la, tot, form, f[0], f[1], f[5], f[4], fp};
   endfunction

   function automatic logic [W-1:0] seen();
      return {out_func, out_rd, out_rs1, out_rs2, out_first, out_last, out_total, out_kind,
              out_set_vlmax, out_keep_vl, out_wr_vec, out_rd_vec, out_flush_pipe};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // expected micro-ops per R1..R6, kind per R7, regions per R8, flush mark per R9, marks per R10
   task automatic send(input logic [1:0] f, input logic [IDX_W-1:0] rd,
                       input logic [IDX_W-1:0] r1, input logic [IDX_W-1:0] r2);
      logic [7:0] c0, c1;
      int n;
      string t;
      bit acc;
      n = 2;
      if (f == 2'd1) begin
         c0 = 8'h20; c1 = 8'h00; t = "R6";
      end else if (f == 2'd0) begin
         if (r1 != 0)      begin c0 = 8'hA0; c1 = 8'h80; t = "R1"; end
         else if (rd != 0) begin c0 = 8'hA1; c1 = 8'h81; t = "R2"; end
         else              begin c0 = 8'hA2; c1 = 8'hA2; t = "R3"; n = 1; end
      end else begin
         if (r1 != 0)      begin c0 = 8'h60; c1 = 8'h40; t = "R4"; end
         else if (rd != 0) begin c0 = 8'h61; c1 = 8'h41; t = "R4"; end
         else              begin c0 = 8'h62; c1 = 8'h72; t = "R5"; end
      end
      if (n == 1) begin
         exp_q.push_back(mk(c0, rd, r1, r2, 1'b1, 1'b1, 2'd1, f, 1'b0));
         tag_q.push_back(t);
      end else begin
         exp_q.push_back(mk(c0, rd, r1, r2, 1'b1, 1'b0, 2'd2, f, 1'b0));
         tag_q.push_back(t);
         exp_q.push_back(mk(c1, rd, r1, r2, 1'b0, 1'b1, 2'd2, f, f == 2'd2));
         tag_q.push_back(t);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_form  = f;
      in_rd    = rd;
      in_rs1   = r1;
      in_rs2   = r2;
      acc = 1'b0;
      while (!acc) begin
         #1ns;
         if (in_ready) begin
            @(posedge clk);
            acc = 1'b1;
         end else begin
            @(negedge clk);
         end
      end
      #1ns;
      in_valid = 1'b0;
   endtask

   // consumer side
   always @(negedge clk) begin
      if (rdy_mode == 0)      out_ready <= 1'b1;
      else if (rdy_mode == 1) out_ready <= ($urandom % 3) != 0;
      else                    out_ready <= 1'b0;
   end

   // monitor
   bit           prev_hold = 1'b0;
   bit           prev_flush = 1'b0;
   logic [W-1:0] prev_word = '0;

   always begin
      @(negedge clk);
      #1ns;
      if (rst_n) begin
         if (prev_hold && !prev_flush)
            check(out_valid && seen() == prev_word, "R11", "held micro-op changed", seen(), prev_word);
         if (out_valid && !out_last)
            check(!in_ready, "R11", "in_ready high mid-sequence", {33'd0, in_ready}, '0);
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R10", "unexpected micro-op", seen(), '0);
            end else begin
               logic [W-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(seen() == e, t, "micro-op mismatch", seen(), e);
            end
         end
         prev_hold  = out_valid && !out_ready;
         prev_word  = seen();
         prev_flush = flush;
      end
   end

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1ns;
      check(!out_valid, "R13", "out_valid after reset", {33'd0, out_valid}, '0);
      check(in_ready, "R13", "in_ready after reset", {33'd0, in_ready}, {33'd0, 1'b1});

      // directed cases, consumer always ready
      rdy_mode = 0;
      send(2'd0, 5'd3, 5'd4, 5'd9);    // R1
      send(2'd0, 5'd5, 5'd0, 5'd1);    // R2
      send(2'd0, 5'd0, 5'd0, 5'd2);    // R3
      send(2'd2, 5'd7, 5'd8, 5'd11);   // R4
      send(2'd2, 5'd2, 5'd0, 5'd12);   // R4
      send(2'd2, 5'd0, 5'd0, 5'd9);    // R5 R9
      send(2'd1, 5'd0, 5'd0, 5'd0);    // R6
      send(2'd1, 5'd1, 5'd6, 5'd3);    // R6
      drain();

      // pseudo-random back-pressure, R11
      rdy_mode = 1;
      for (int i = 0; i < 60; i++) begin
         logic [1:0] f;
         logic [IDX_W-1:0] rd, r1;
         f  = 2'($urandom % 3);
         rd = ($urandom % 3 == 0) ? '0 : IDX_W'($urandom);
         r1 = ($urandom % 3 == 0) ? '0 : IDX_W'($urandom);
         send(f, rd, r1, IDX_W'($urandom));
      end
      drain();

      // flush with a pending second micro-op, R12
      rdy_mode = 2;
      send(2'd2, 5'd4, 5'd5, 5'd6);
      @(negedge clk);
      flush = 1'b1;
      exp_q.delete();
      tag_q.delete();
      #1ns;
      check(!in_ready, "R12", "in_ready during flush", {33'd0, in_ready}, '0);
      @(negedge clk);
      flush = 1'b0;
      #1ns;
      check(!out_valid, "R12", "out_valid after flush", {33'd0, out_valid}, '0);
      check(in_ready, "R12", "in_ready after flush", {33'd0, in_ready}, {33'd0, 1'b1});
      rdy_mode = 0;
      send(2'd1, 5'd2, 5'd3, 5'd4);    // stale second micro-op must not appear
      drain();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule